// File: doc/BRIEF.md
# Looping Pattern Exchange Tester

This block exercises a 32-bit chip-to-chip bus with all of its lines switching together. A host with an 8-bit port first fills a transmit buffer of up to 512 words. A start command then replays that pattern onto the outgoing bus over and over until a stop command arrives. The returning bus is sampled into a 512-word capture buffer. Capture begins after a programmable number of cycles, so that it lines up with the round trip through the far device. Once the run is over, the host reads both buffers back and compares them.

A small sequencer has four states, and one test clock drives everything. `ST_IDLE` is the only state in which the host may touch the buffers. A start in idle goes to `ST_WAIT`, or straight to `ST_CAPT` when the latency is zero. `ST_WAIT` counts the latency down and then moves to `ST_CAPT`. `ST_CAPT` stores one word per cycle and moves to `ST_HOLD` on the 512th word. `ST_HOLD` keeps transmitting without storing. A stop in any active state returns to `ST_IDLE`.

Top module: `pattern_loop_tester`

## Requirements
- R1: After reset, `running_o` and `cap_full_o` are 0, `cap_cnt_o` is 0 and `bus_out_o` is zero.
- R2: The host byte address is {word index, lane}. Lane 0 is bits 7:0 and lane 3 is bits 31:24. `host_buf_i`=0 selects the transmit buffer and 1 selects the capture buffer. A read request returns its byte on `host_rdata_o` with `host_rvalid_o`=1 in the cycle after the request edge. Host writes to the capture buffer have no effect.
- R3: The loop length is one plus the word index of the most recent lane-3 write to the transmit buffer. Call the edge that accepts start edge 0. In the cycle after edge k, `bus_out_o` carries transmit word (k mod length).
- R4: With a loop length of zero, `bus_out_o` stays zero for the whole run, and the captured words are zero.
- R5: `bus_out_o` is zero whenever the block is not running. A start that arrives while running, or together with stop, is ignored.
- R6: With latency L (`latency_i`, sampled at the start edge), capture word j holds the `bus_in_i` value of the cycle after edge j+L.
- R7: Capture stops after 512 words. At that point `cap_full_o` rises and transmission continues until stop.
- R8: A stop ends the run at its edge. Nothing is captured on that edge, `running_o` falls and the bus returns to zero.
- R9: While running, host writes do not change either buffer and host reads return no `host_rvalid_o`.
- R10: `cap_cnt_o` counts the stored words. It rises by one per stored word, and a start clears it together with `cap_full_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Start command pulse |
| stop_i | input | 1 | Stop command pulse |
| latency_i | input | 8 | Capture latency in cycles |
| bus_out_o | output | 32 | Outgoing pattern bus |
| bus_in_i | input | 32 | Returning bus |
| host_buf_i | input | 1 | Buffer select: 0 transmit, 1 capture |
| host_addr_i | input | 11 | Host byte address {word, lane} |
| host_wr_i | input | 1 | Host byte write strobe |
| host_rd_i | input | 1 | Host byte read request |
| host_wdata_i | input | 8 | Host write byte |
| host_rdata_o | output | 8 | Host read byte |
| host_rvalid_o | output | 1 | Read byte valid |
| running_o | output | 1 | Run in progress |
| cap_full_o | output | 1 | Capture buffer full |
| cap_cnt_o | output | 10 | Number of captured words |

## Verification
The assertions check four rules on every cycle:
- the outgoing bus is quiet whenever the block is idle;
- the capture count only steps by one or clears, and never passes the depth, with the full flag tied to the full count;
- a run ends only through stop;
- no read data is returned during a run.

The bench scenarios are needed for everything that depends on data:
- the replayed word order and its wrap at the loaded length;
- the alignment of captured words for several latencies against a modelled delay line;
- the all-zero empty-buffer run and saturation at 512 words;
- host accesses that are dropped during a run or aimed at the capture buffer, as shown by reading the buffers back.

// File: rtl/plt_pkg.sv
package plt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_CAPT = 2'd2,
        ST_HOLD = 2'd3
    } plt_state_e;
endpackage

// File: rtl/plt_ram.sv
// Simple dual-port buffer: lane-masked write port, registered read port.
module plt_ram #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 512,
    parameter int LANES = 4,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = WIDTH / LANES
) (
    input  logic             clk,
    input  logic             we_i,
    input  logic [LANES-1:0] be_i,
    input  logic [AW-1:0]    waddr_i,
    input  logic [WIDTH-1:0] wdata_i,
    input  logic [AW-1:0]    raddr_i,
    output logic [WIDTH-1:0] rdata_o
);
    logic [WIDTH-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) begin
            for (int b = 0; b < LANES; b++) begin
                if (be_i[b]) mem_q[waddr_i][b*LW +: LW] <= wdata_i[b*LW +: LW];
            end
        end
        rdata_o <= mem_q[raddr_i];
    end
endmodule

// File: rtl/plt_seq.sv
// Run sequencer: loop pointer, latency countdown, capture pointer.
module plt_seq
    import plt_pkg::*;
#(
    parameter int DEPTH = 512,
    parameter int LAT_W = 8,
    localparam int AW    = $clog2(DEPTH),
    localparam int CNT_W = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic [LAT_W-1:0] latency_i,
    input  logic [CNT_W-1:0] tx_len_i,
    output logic [AW-1:0]    tx_addr_o,
    output logic             tx_own_o,
    output logic             drive_o,
    output logic             cap_we_o,
    output logic [AW-1:0]    cap_addr_o,
    output logic             running_o,
    output logic             cap_full_o,
    output logic [CNT_W-1:0] cap_cnt_o
);
    plt_state_e state_q, state_d;
    logic [LAT_W-1:0] lat_q;
    logic [AW-1:0]    ptr_q, wptr_q;
    logic [CNT_W-1:0] cnt_q;
    logic             full_q, drive_q;
    logic             go, halt;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p,
                                           input logic [CNT_W-1:0] len);
        logic [CNT_W-1:0] sum;
        sum = {1'b0, p} + CNT_W'(1);
        return (sum >= len) ? '0 : sum[AW-1:0];
    endfunction

    assign go   = (state_q == ST_IDLE) && start_i && !stop_i;
    assign halt = (state_q != ST_IDLE) && stop_i;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (go) state_d = (latency_i == '0) ? ST_CAPT : ST_WAIT;
            ST_WAIT: if (stop_i) state_d = ST_IDLE;
                     else if (lat_q == '0) state_d = ST_CAPT;
            ST_CAPT: if (stop_i) state_d = ST_IDLE;
                     else if (wptr_q == AW'(DEPTH - 1)) state_d = ST_HOLD;
            ST_HOLD: if (stop_i) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_q   <= '0;
            ptr_q   <= '0;
            wptr_q  <= '0;
            cnt_q   <= '0;
            full_q  <= 1'b0;
            drive_q <= 1'b0;
        end else if (go) begin
            lat_q   <= latency_i - LAT_W'(1);
            ptr_q   <= step('0, tx_len_i);
            wptr_q  <= '0;
            cnt_q   <= '0;
            full_q  <= 1'b0;
            drive_q <= 1'b1;
        end else if (halt) begin
            drive_q <= 1'b0;
        end else if (state_q != ST_IDLE) begin
            ptr_q <= step(ptr_q, tx_len_i);
            if (state_q == ST_WAIT && lat_q != '0) lat_q <= lat_q - LAT_W'(1);
            if (cap_we_o) begin
                wptr_q <= wptr_q + AW'(1);
                cnt_q  <= cnt_q + CNT_W'(1);
                if (wptr_q == AW'(DEPTH - 1)) full_q <= 1'b1;
            end
        end
    end

    assign cap_we_o   = (state_q == ST_CAPT) && !stop_i;
    assign cap_addr_o = wptr_q;
    assign tx_addr_o  = go ? '0 : ptr_q;
    assign tx_own_o   = go || (state_q != ST_IDLE);
    assign drive_o    = drive_q;
    assign running_o  = (state_q != ST_IDLE);
    assign cap_full_o = full_q;
    assign cap_cnt_o  = cnt_q;
endmodule

// File: rtl/plt_host.sv
// Host byte access: lane decode, loop length tracking, read-back select.
module plt_host #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 512,
    localparam int LANES  = WIDTH / 8,
    localparam int LB     = $clog2(LANES),
    localparam int AW     = $clog2(DEPTH),
    localparam int ADDR_W = AW + LB,
    localparam int CNT_W  = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ok_i,
    input  logic              host_buf_i,
    input  logic [ADDR_W-1:0] host_addr_i,
    input  logic              host_wr_i,
    input  logic              host_rd_i,
    input  logic [7:0]        host_wdata_i,
    input  logic [WIDTH-1:0]  tx_q_i,
    input  logic [WIDTH-1:0]  cap_q_i,
    output logic              tx_we_o,
    output logic [LANES-1:0]  tx_be_o,
    output logic [WIDTH-1:0]  tx_wdata_o,
    output logic [AW-1:0]     word_o,
    output logic [CNT_W-1:0]  tx_len_o,
    output logic [7:0]        host_rdata_o,
    output logic              host_rvalid_o
);
    logic [LB-1:0]    lane;
    logic [LB-1:0]    rlane_q;
    logic             rbuf_q, rvalid_q;
    logic [CNT_W-1:0] len_q;
    logic [WIDTH-1:0] rword;

    assign word_o     = host_addr_i[ADDR_W-1:LB];
    assign lane       = host_addr_i[LB-1:0];
    assign tx_we_o    = ok_i && host_wr_i && !host_buf_i;
    assign tx_be_o    = LANES'(1) << lane;
    assign tx_wdata_o = {LANES{host_wdata_i}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q    <= '0;
            rvalid_q <= 1'b0;
            rbuf_q   <= 1'b0;
            rlane_q  <= '0;
        end else begin
            if (tx_we_o && lane == LB'(LANES - 1))
                len_q <= {1'b0, word_o} + CNT_W'(1);
            rvalid_q <= ok_i && host_rd_i;
            if (ok_i && host_rd_i) begin
                rbuf_q  <= host_buf_i;
                rlane_q <= lane;
            end
        end
    end

    assign rword         = rbuf_q ? cap_q_i : tx_q_i;
    assign host_rdata_o  = rword[rlane_q*8 +: 8];
    assign host_rvalid_o = rvalid_q;
    assign tx_len_o      = len_q;
endmodule

// File: rtl/pattern_loop_tester.sv
module pattern_loop_tester #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 512,
    parameter int LAT_W  = 8,
    localparam int LANES  = DATA_W / 8,
    localparam int AW     = $clog2(DEPTH),
    localparam int ADDR_W = AW + $clog2(LANES),
    localparam int CNT_W  = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic [LAT_W-1:0]  latency_i,
    output logic [DATA_W-1:0] bus_out_o,
    input  logic [DATA_W-1:0] bus_in_i,
    input  logic              host_buf_i,
    input  logic [ADDR_W-1:0] host_addr_i,
    input  logic              host_wr_i,
    input  logic              host_rd_i,
    input  logic [7:0]        host_wdata_i,
    output logic [7:0]        host_rdata_o,
    output logic              host_rvalid_o,
    output logic              running_o,
    output logic              cap_full_o,
    output logic [CNT_W-1:0]  cap_cnt_o
);
    logic [AW-1:0]     seq_addr, cap_waddr, host_word, tx_raddr;
    logic              tx_own, drive, cap_we, tx_we, host_ok;
    logic [LANES-1:0]  tx_be;
    logic [DATA_W-1:0] tx_wdata, tx_q, cap_q;
    logic [CNT_W-1:0]  tx_len;

    assign host_ok  = !running_o && !start_i;
    assign tx_raddr = tx_own ? seq_addr : host_word;

    plt_seq #(.DEPTH(DEPTH), .LAT_W(LAT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
        .latency_i(latency_i), .tx_len_i(tx_len),
        .tx_addr_o(seq_addr), .tx_own_o(tx_own), .drive_o(drive),
        .cap_we_o(cap_we), .cap_addr_o(cap_waddr), .running_o(running_o),
        .cap_full_o(cap_full_o), .cap_cnt_o(cap_cnt_o)
    );

    plt_host #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_host (
        .clk(clk), .rst_n(rst_n), .ok_i(host_ok), .host_buf_i(host_buf_i),
        .host_addr_i(host_addr_i), .host_wr_i(host_wr_i), .host_rd_i(host_rd_i),
        .host_wdata_i(host_wdata_i), .tx_q_i(tx_q), .cap_q_i(cap_q),
        .tx_we_o(tx_we), .tx_be_o(tx_be), .tx_wdata_o(tx_wdata),
        .word_o(host_word), .tx_len_o(tx_len),
        .host_rdata_o(host_rdata_o), .host_rvalid_o(host_rvalid_o)
    );

    plt_ram #(.WIDTH(DATA_W), .DEPTH(DEPTH), .LANES(LANES)) u_tx_ram (
        .clk(clk), .we_i(tx_we), .be_i(tx_be), .waddr_i(host_word),
        .wdata_i(tx_wdata), .raddr_i(tx_raddr), .rdata_o(tx_q)
    );

    plt_ram #(.WIDTH(DATA_W), .DEPTH(DEPTH), .LANES(LANES)) u_cap_ram (
        .clk(clk), .we_i(cap_we), .be_i({LANES{1'b1}}), .waddr_i(cap_waddr),
        .wdata_i(bus_in_i), .raddr_i(host_word), .rdata_o(cap_q)
    );

    assign bus_out_o = (drive && tx_len != '0) ? tx_q : '0;
endmodule

// File: rtl/plt_tester_chk.sv
module plt_tester_chk #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 512,
    localparam int CNT_W = $clog2(DEPTH) + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stop_i,
    input logic [DATA_W-1:0] bus_out_o,
    input logic              running_o,
    input logic              cap_full_o,
    input logic [CNT_W-1:0]  cap_cnt_o,
    input logic              host_rvalid_o
);
    // R5
    idle_bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !running_o |-> bus_out_o == '0);

    // R7
    cnt_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_cnt_o <= CNT_W'(DEPTH));

    // R7
    full_at_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_full_o |-> cap_cnt_o == CNT_W'(DEPTH));

    // R10
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_cnt_o != $past(cap_cnt_o)) |->
            (cap_cnt_o == $past(cap_cnt_o) + CNT_W'(1) || cap_cnt_o == '0));

    // R8
    end_by_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(running_o) |-> $past(stop_i));

    // R9
    no_read_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running_o && $past(running_o)) |-> !host_rvalid_o);
endmodule

bind pattern_loop_tester plt_tester_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .stop_i(stop_i), .bus_out_o(bus_out_o),
    .running_o(running_o), .cap_full_o(cap_full_o), .cap_cnt_o(cap_cnt_o),
    .host_rvalid_o(host_rvalid_o)
);

// File: tb/pattern_loop_tester_tb.sv
module pattern_loop_tester_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0, stop_i = 1'b0;
    logic [7:0]  latency_i = '0;
    logic [31:0] bus_out_o, bus_in_i;
    logic        host_buf_i = 1'b0, host_wr_i = 1'b0, host_rd_i = 1'b0;
    logic [10:0] host_addr_i = '0;
    logic [7:0]  host_wdata_i = '0, host_rdata_o;
    logic        host_rvalid_o, running_o, cap_full_o;
    logic [9:0]  cap_cnt_o;

    int n_tests = 0, n_fail = 0;
    int lat_tb = 0;
    int len_tb = 0;
    logic [31:0] dly [16];

    always #5 clk = ~clk;

    pattern_loop_tester u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
        .latency_i(latency_i), .bus_out_o(bus_out_o), .bus_in_i(bus_in_i),
        .host_buf_i(host_buf_i), .host_addr_i(host_addr_i), .host_wr_i(host_wr_i),
        .host_rd_i(host_rd_i), .host_wdata_i(host_wdata_i),
        .host_rdata_o(host_rdata_o), .host_rvalid_o(host_rvalid_o),
        .running_o(running_o), .cap_full_o(cap_full_o), .cap_cnt_o(cap_cnt_o)
    );

    // far-side model: loopback through lat_tb register stages
    always_ff @(posedge clk) begin
        dly[0] <= bus_out_o;
        for (int i = 1; i < 16; i++) dly[i] <= dly[i-1];
    end
    assign bus_in_i = (lat_tb == 0) ? bus_out_o : dly[lat_tb-1];

    function automatic logic [31:0] pat(input int i);
        return 32'h1234_5678 ^ (32'(i) * 32'h0101_0107);
    endfunction

    function automatic logic [31:0] expw(input int k);
        return (len_tb == 0) ? 32'h0 : pat(k % len_tb);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_byte(input bit buf_sel, input int word, input int lane,
                           input logic [7:0] d);
        host_buf_i = buf_sel; host_addr_i = 11'((word << 2) | lane);
        host_wdata_i = d; host_wr_i = 1'b1;
        @(negedge clk);
        host_wr_i = 1'b0;
    endtask

    task automatic wr_word(input int word, input logic [31:0] d);
        for (int b = 0; b < 4; b++) wr_byte(1'b0, word, b, d[b*8 +: 8]);
    endtask

    task automatic rd_word(input bit buf_sel, input int word,
                           output logic [31:0] d, output bit vld);
        vld = 1'b1;
        for (int b = 0; b < 4; b++) begin
            host_buf_i = buf_sel; host_addr_i = 11'((word << 2) | b);
            host_rd_i = 1'b1;
            @(negedge clk);
            d[b*8 +: 8] = host_rdata_o;
            vld &= host_rvalid_o;
        end
        host_rd_i = 1'b0;
    endtask

    // one run: n bus cycles checked, then stop; capture contents verified
    task automatic run(input int lat, input int n, input bit restart, input bit poke,
                       input string req);
        int exp_cnt;
        logic [31:0] d;
        bit v, all_ok;
        lat_tb = lat; latency_i = 8'(lat);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int k = 0; k < n; k++) begin
            chk(bus_out_o === expw(k), req, bus_out_o, expw(k));
            if (k == 3 && poke) chk(host_rvalid_o === 1'b0, "R9 no read data", 32'(host_rvalid_o), 0);
            start_i = (k == 2 && restart);
            host_wr_i = (k == 2 && poke); host_rd_i = (k == 2 && poke);
            host_buf_i = 1'b0; host_addr_i = '0; host_wdata_i = 8'hEE;
            @(negedge clk);
            start_i = 1'b0; host_wr_i = 1'b0; host_rd_i = 1'b0;
        end
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
        exp_cnt = (n - lat < 0) ? 0 : ((n - lat > 512) ? 512 : n - lat);
        chk(running_o === 1'b0, "R8 stopped", 32'(running_o), 0);
        chk(bus_out_o === 32'h0, "R8 bus quiet", bus_out_o, 0);
        chk(cap_cnt_o === 10'(exp_cnt), "R10 count", 32'(cap_cnt_o), 32'(exp_cnt));
        chk(cap_full_o === (exp_cnt == 512), "R7 full flag", 32'(cap_full_o), 32'(exp_cnt == 512));
        all_ok = 1'b1;
        for (int j = 0; j < exp_cnt; j++) begin
            rd_word(1'b1, j, d, v);
            if (!(v && d === expw(j))) begin
                all_ok = 1'b0;
                chk(1'b0, "R6 capture word", d, expw(j));
            end
        end
        chk(all_ok, "R6 capture alignment", 32'(exp_cnt), 32'(exp_cnt));
    endtask

    task automatic t_reset;
        chk(running_o === 1'b0, "R1 running", 32'(running_o), 0);
        chk(cap_full_o === 1'b0, "R1 full", 32'(cap_full_o), 0);
        chk(cap_cnt_o === 10'd0, "R1 count", 32'(cap_cnt_o), 0);
        chk(bus_out_o === 32'h0, "R1 bus", bus_out_o, 0);
    endtask

    task automatic t_empty;
        len_tb = 0;
        run(1, 8, 1'b0, 1'b0, "R4 empty run");
    endtask

    task automatic t_load;
        logic [31:0] d;
        bit v;
        for (int i = 0; i < 5; i++) wr_word(i, pat(i));
        len_tb = 5;
        for (int i = 0; i < 5; i++) begin
            rd_word(1'b0, i, d, v);
            chk(v && d === pat(i), "R2 tx readback", d, pat(i));
        end
    endtask

    task automatic t_both_cmds;
        start_i = 1'b1; stop_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; stop_i = 1'b0;
        chk(running_o === 1'b0, "R5 start with stop", 32'(running_o), 0);
        chk(bus_out_o === 32'h0, "R5 idle bus", bus_out_o, 0);
    endtask

    task automatic t_ignored;
        logic [31:0] d;
        bit v;
        rd_word(1'b0, 0, d, v);
        chk(v && d === pat(0), "R9 tx untouched by run write", d, pat(0));
        rd_word(1'b1, 0, d, v);
        wr_byte(1'b1, 0, 0, 8'h00);
        rd_word(1'b1, 0, d, v);
        chk(v && d === expw(0), "R2 capture write ignored", d, expw(0));
    endtask

    task automatic t_shorten;
        wr_byte(1'b0, 1, 3, pat(1)[31:24]);
        len_tb = 2;
        run(2, 9, 1'b0, 1'b0, "R3 shortened loop");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_empty();
        t_load();
        t_both_cmds();
        run(0, 10, 1'b1, 1'b0, "R3 R5 loop with restart");
        run(5, 12, 1'b0, 1'b1, "R3 R9 latency 5 with host poke");
        t_ignored();
        t_shorten();
        run(3, 520, 1'b0, 1'b0, "R7 full capture");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule